// File: doc/BRIEF.md
# Random Allocation Tag Generator

This block picks a 4-bit allocation tag for a tagged-pointer scheme and writes it into bits [59:56] of a 64-bit pointer. In random mode, a 16-bit linear feedback seed is stepped four times, and the four feedback bits form an offset. Starting from the tag kept in a state register, the block then counts forward that many permitted tag values, wrapping modulo 16. A tag is permitted when its bit is clear in the exclusion mask. When the request completes, the new tag and the advanced seed are written back to the state register, so the next random request continues from there.

In explicit mode, the offset comes from a request input and the start tag is the tag already in the pointer. Only the global exclusion mask applies. The pointer also has a sign-extended address offset added to it before the new tag is inserted, and the state register is not touched.

The walk moves one tag value per clock cycle. A request is accepted while the block is idle; `busy` stays high until a one-cycle `done` pulse marks the result. Software initialises or reloads the seed and the start tag through the load port.

Top module: `alloc_tag_gen`

## Requirements
- R1: In random mode the effective exclusion mask is `req_excl | glob_excl`, where bit k set forbids tag value k.
- R2: In random mode each of four steps computes b = s[5]^s[3]^s[2]^s[0] and then s = {b, s[15:1]}, where s is the seed in state bits [23:8]. The b of step i (i = 0..3) becomes offset bit i. On completion the state becomes {advanced seed, 4'b0000, result tag}.
- R3: If all 16 effective exclusion bits are set, the result tag is 0. In random mode the seed still advances.
- R4: With offset 0 the result is the start tag if it is permitted. Otherwise the tag increments modulo 16 until it reaches a permitted value.
- R5: With offset N > 0 the tag advances N times. Each advance increments modulo 16 at least once and keeps incrementing while the tag is excluded.
- R6: Explicit mode (`req_mode`=1) behaves as follows:
  - The start tag is `req_ptr[59:56]`, the offset is `req_tag_off`, and only `glob_excl` applies.
  - The result pointer is `req_ptr` plus the sign-extended `req_addr_off`, with bits [59:56] then replaced by the tag.
  - The state register is unchanged.
- R7: In random mode every result pointer bit other than [59:56] equals the corresponding bit of `req_ptr`.
- R8: A request is accepted only while `busy` is low. `busy` is high in the cycle after acceptance and stays high until `done` pulses for one cycle, at which point `busy` falls and `res_ptr` holds the result. Requests while busy are ignored.
- R9: The load port behaves as follows:
  - `st_load` while idle writes `st_wdata` into the state register at the next edge.
  - A load while busy is ignored.
  - When a load and a request arrive together, the load is taken and the request is dropped.
- R10: A zero seed stays zero and yields offset 0.
- R11: After reset `state`, `res_ptr`, `busy` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 1 | 0 random offset, 1 explicit offset |
| req_ptr | input | PTR_W | Source pointer |
| req_excl | input | 16 | Per-request exclusion mask (random mode) |
| req_tag_off | input | 4 | Explicit tag offset |
| req_addr_off | input | AOFF_W | Signed address offset (explicit mode) |
| glob_excl | input | 16 | Global exclusion mask |
| st_load | input | 1 | State load strobe |
| st_wdata | input | 24 | State load value |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result pulse |
| res_ptr | output | PTR_W | Pointer carrying the new tag |
| state | output | 24 | Seed [23:8] and last tag [3:0] |

## Verification
The inline properties are checked on every cycle. They cover the following:
- Each result tag is either permitted by the captured mask or is zero when every tag is excluded.
- `done` only follows a busy cycle and never lasts two cycles.
- The state register changes only on a random-mode completion or an idle load.

The exact tag values produced by the shift sequence and the counted walk, the pointer arithmetic of explicit mode, and the handling of strobes that arrive mid-walk are shown only by the bench scenarios, which compare against an independent model.

// File: rtl/alloc_tag_gen.sv
module alloc_tag_gen #(
  parameter int PTR_W   = 64,
  parameter int TAG_LSB = 56,
  parameter int AOFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_mode,
  input  logic [PTR_W-1:0]  req_ptr,
  input  logic [15:0]       req_excl,
  input  logic [3:0]        req_tag_off,
  input  logic [AOFF_W-1:0] req_addr_off,
  input  logic [15:0]       glob_excl,
  input  logic              st_load,
  input  logic [23:0]       st_wdata,
  output logic              busy,
  output logic              done,
  output logic [PTR_W-1:0]  res_ptr,
  output logic [23:0]       state
);

  localparam int TAG_W  = 4;
  localparam int SEED_W = 16;
  localparam int SEED_LSB = 8;
  localparam int EXT_W  = PTR_W - AOFF_W;

  function automatic logic [SEED_W+TAG_W-1:0] step4(input logic [SEED_W-1:0] s_in);
    logic [SEED_W-1:0] s;
    logic [TAG_W-1:0]  o;
    logic              b;
    s = s_in;
    o = '0;
    for (int i = 0; i < TAG_W; i++) begin
      b    = s[5] ^ s[3] ^ s[2] ^ s[0];
      o[i] = b;
      s    = {b, s[SEED_W-1:1]};
    end
    return {s, o};
  endfunction

  logic              busy_q, done_q, mode_q;
  logic [TAG_W-1:0]  cur_q, rem_q;
  logic [15:0]       excl_q;
  logic [SEED_W-1:0] seed_q;
  logic [PTR_W-1:0]  base_q, res_q;
  logic [23:0]       state_q;

  logic [SEED_W-1:0] seed_adv;
  logic [TAG_W-1:0]  rnd_off;
  logic              accept, all_ex, fin;
  logic [TAG_W-1:0]  nxt, res_tag;
  logic [PTR_W-1:0]  sum_ptr;

  assign {seed_adv, rnd_off} = step4(state_q[SEED_LSB +: SEED_W]);
  assign accept  = req_valid && !busy_q && !st_load;
  assign sum_ptr = req_ptr + {{EXT_W{req_addr_off[AOFF_W-1]}}, req_addr_off};
  assign all_ex  = &excl_q;
  assign nxt     = cur_q + 4'd1;
  assign fin     = busy_q && (all_ex || (rem_q == '0 && !excl_q[cur_q]));
  assign res_tag = all_ex ? '0 : cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mode_q  <= 1'b0;
      cur_q   <= '0;
      rem_q   <= '0;
      excl_q  <= '0;
      seed_q  <= '0;
      base_q  <= '0;
      res_q   <= '0;
      state_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && st_load) begin
        state_q <= st_wdata;
      end else if (accept) begin
        busy_q <= 1'b1;
        mode_q <= req_mode;
        seed_q <= seed_adv;
        if (req_mode) begin
          cur_q  <= req_ptr[TAG_LSB +: TAG_W];
          rem_q  <= req_tag_off;
          excl_q <= glob_excl;
          base_q <= sum_ptr;
        end else begin
          cur_q  <= state_q[TAG_W-1:0];
          rem_q  <= rnd_off;
          excl_q <= req_excl | glob_excl;
          base_q <= req_ptr;
        end
      end else if (fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        res_q  <= base_q;
        res_q[TAG_LSB +: TAG_W] <= res_tag;
        if (!mode_q) state_q <= {seed_q, 4'b0000, res_tag};
      end else if (busy_q) begin
        cur_q <= nxt;
        if (rem_q != '0 && !excl_q[nxt]) rem_q <= rem_q - 4'd1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign res_ptr = res_q;
  assign state   = state_q;

  // R8: a result pulse follows a busy cycle
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));

  // R8: the pulse lasts one cycle
  p_single_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5 and R3: the tag is permitted, or zero when every tag is excluded
  p_result_allowed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((&excl_q) ? (res_q[TAG_LSB +: TAG_W] == '0)
                          : !excl_q[res_q[TAG_LSB +: TAG_W]]));

  // R6: explicit mode leaves the state alone
  p_expl_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mode_q) |-> $stable(state_q));

  // R9: the state moves only on a random completion or an idle load
  p_state_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !$past(st_load && !busy_q)) |-> $stable(state_q));

endmodule

// File: tb/alloc_tag_gen_tb_top.sv
`timescale 1ns/1ps
module alloc_tag_gen_tb_top;
  localparam int PTR_W = 64;
  localparam int AOFF_W = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_mode = 0, st_load = 0;
  logic [PTR_W-1:0] req_ptr = '0;
  logic [15:0] req_excl = '0, glob_excl = '0;
  logic [3:0] req_tag_off = '0;
  logic [AOFF_W-1:0] req_addr_off = '0;
  logic [23:0] st_wdata = '0;
  logic busy, done;
  logic [PTR_W-1:0] res_ptr;
  logic [23:0] state;

  alloc_tag_gen dut_i (.clk, .rst_n, .req_valid, .req_mode, .req_ptr, .req_excl,
    .req_tag_off, .req_addr_off, .glob_excl, .st_load, .st_wdata,
    .busy, .done, .res_ptr, .state);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [23:0] m_state = '0;
  logic [PTR_W-1:0] exp_ptr;
  logic [23:0] exp_state;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [19:0] m_rnd(input logic [15:0] s_in);
    logic [15:0] s = s_in;
    logic [3:0] o = 0;
    for (int i = 0; i < 4; i++) begin
      o[i] = s[0] ^ s[2] ^ s[3] ^ s[5];
      s = {o[i], s[15:1]};
    end
    return {s, o};
  endfunction

  function automatic logic [3:0] m_pick(input logic [3:0] st, input logic [3:0] off, input logic [15:0] ex);
    logic [3:0] t = st;
    if (ex == 16'hffff) return 4'd0;
    if (off == 0) begin
      for (int j = 0; j < 16 && ex[t]; j++) t = t + 1;
    end else begin
      for (int k = 0; k < 16; k++) if (k < off) begin
        t = t + 1;
        for (int j = 0; j < 16 && ex[t]; j++) t = t + 1;
      end
    end
    return t;
  endfunction

  task automatic start_req(input bit md, input logic [63:0] p, input logic [15:0] rx,
                           input logic [15:0] gx, input logic [3:0] to, input logic [15:0] ao);
    logic [19:0] r;
    logic [3:0] tg;
    logic [63:0] b;
    if (md) begin
      tg = m_pick(p[59:56], to, gx);
      b = p + {{48{ao[15]}}, ao};
      exp_state = m_state;
    end else begin
      r = m_rnd(m_state[23:8]);
      tg = m_pick(m_state[3:0], r[3:0], rx | gx);
      b = p;
      exp_state = {r[19:4], 4'b0000, tg};
    end
    b[59:56] = tg;
    exp_ptr = b;
    @(negedge clk);
    req_valid = 1; req_mode = md; req_ptr = p; req_excl = rx; glob_excl = gx;
    req_tag_off = to; req_addr_off = ao;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_req(input string rq);
    int n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk(done, {rq, " done"}, done, 1);
    chk(res_ptr == exp_ptr, rq, res_ptr, exp_ptr);
    chk(state == exp_state, {rq, " state"}, state, exp_state);
    m_state = exp_state;
    @(negedge clk);
    chk(!done && !busy, "R8 pulse ends", {done, busy}, 0);
  endtask

  task automatic load(input logic [23:0] v);
    @(negedge clk);
    st_load = 1; st_wdata = v;
    @(negedge clk);
    st_load = 0;
    m_state = v;
    chk(state == v, "R9 idle load", state, v);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(state == 0 && res_ptr == 0 && !busy && !done, "R11 reset", {state, busy, done}, 0);
    rst_n = 1;

    load(24'hACE105);
    start_req(0, 64'h1234_5678_9ABC_DEF0, 16'h0000, 16'h0000, 0, 0);
    chk(busy, "R8 busy after accept", busy, 1);
    finish_req("R2 R7 random no exclusion");

    load(24'h000007);
    start_req(0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0);
    finish_req("R10 zero seed");
    load(24'h000007);
    start_req(0, 64'h0, 16'h0180, 0, 0, 0);
    finish_req("R4 offset zero skip");
    load(24'h00000F);
    start_req(0, 64'h0, 16'h8001, 16'h0002, 0, 0);
    finish_req("R4 R1 wrap past 15");

    load(24'h5A5A03);
    start_req(0, 64'h0F00_0000_0000_0001, 16'h00FF, 16'hFF00, 0, 0);
    finish_req("R3 R1 all excluded");

    load(24'hBEEF02);
    start_req(0, 64'h0, 16'h5555, 0, 0, 0);
    finish_req("R5 random skip even");

    load(24'h123409);
    start_req(1, 64'h0E00_0000_0000_0010, 16'hFFFF, 16'h8001, 4'd3, 16'hFFE0);
    finish_req("R6 explicit mode");
    start_req(1, 64'h7F00_0000_0000_FFFF, 0, 0, 4'd0, 16'h0001);
    finish_req("R6 explicit carry");

    start_req(1, 64'h0000_0000_0000_0000, 0, 16'hFFFE, 4'd15, 16'h0000);
    repeat (20) @(negedge clk);
    chk(busy, "R8 still busy", busy, 1);
    req_valid = 1; req_mode = 0; req_ptr = '1; st_load = 1; st_wdata = 24'hFFFFFF;
    @(negedge clk);
    req_valid = 0; st_load = 0;
    finish_req("R8 R9 strobes while busy ignored");

    @(negedge clk);
    req_valid = 1; req_mode = 0; st_load = 1; st_wdata = 24'h77770A;
    @(negedge clk);
    req_valid = 0; st_load = 0;
    m_state = 24'h77770A;
    chk(!busy && state == 24'h77770A, "R9 load beats request", {busy, state}, 24'h77770A);

    for (int it = 0; it < 300; it++) begin
      logic [63:0] p = {$urandom, $urandom};
      logic [15:0] rx = $urandom, gx = $urandom;
      if (it % 7 == 0) load({$urandom} & 24'hFFFF0F);
      if (it % 5 == 0) rx = rx | 16'hF0F0;
      if (it % 11 == 0) begin rx = 16'hFFFF; end
      start_req(it[0], p, rx, gx & 16'h7FFF, 4'($urandom), 16'($urandom));
      finish_req(it[0] ? "R6 random explicit" : "R5 random request");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule